// File: doc/BRIEF.md
# Encoder Input Conditioner

This block cleans up the three raw signals coming from an incremental encoder (phase A, phase B and the once-per-revolution index) before they reach a counter. Each raw pin first passes through a two-flop synchroniser. It then goes through a per-channel enable and a per-channel polarity flip, and finally through a three-sample majority-free glitch filter. The filter only accepts a new level after three consecutive equal samples.

The filter samples on a clock enable taken from a free-running pre-divider. A 3-bit code selects the sampling interval, so the filter can reject glitches from a few nanoseconds up to several hundred. A bypass input skips the filter entirely. A global enable forces every output low and clears the filter history. The index channel also produces a one-clock strobe on each rising edge of its conditioned level.

Top module: `enc_front`

## Requirements
- R1: Each raw input is synchronised by two flops. With the filter bypassed, a change on a raw pin appears on its level output after exactly two rising clock edges.
- R2: When its bit in `ch_inv` is 1, a channel's level is inverted. Bit 0 is A, bit 1 is B and bit 2 is index, for every 3-bit port.
- R3: When its bit in `ch_en` is 0, a channel's level output is 0 whatever its raw pin or inversion bit holds.
- R4: When `flt_bypass` is 1, the level outputs follow the synchronised, enabled and inverted inputs without filtering.
- R5: With the filter active, a level output changes only after three consecutive equal samples of the new value. A pulse that spans at most two samples (shorter than twice the sample interval) is rejected.
- R6: The sample interval in clocks is 1, 2, 4, 16 and 32 for `div_sel` values 0, 1, 2, 3 and 4, and 64 for value 5.
- R7: The `div_sel` values 6 and 7 give the same 64-clock interval as value 5.
- R8: `idx_rise` is high for exactly one clock each time the index level output goes from 0 to 1, and never on a falling edge.
- R9: While `ctl_en` is 0, all level outputs and `idx_rise` are 0 and the filter history is cleared. After re-enabling, a filtered level must again collect three samples before it goes high.
- R10: During and straight after reset, all level outputs and `idx_rise` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Global enable for the whole conditioner |
| flt_bypass | input | 1 | 1 skips the glitch filter |
| div_sel | input | 3 | Filter sample-interval code |
| ch_en | input | 3 | Per-channel enable (A, B, index) |
| ch_inv | input | 3 | Per-channel polarity flip (A, B, index) |
| enc_in | input | 3 | Raw encoder pins (A, B, index) |
| lvl_out | output | 3 | Conditioned levels (A, B, index) |
| idx_rise | output | 1 | One-clock strobe on index rising edge |

## Verification
The hardest behaviour to reach from the ports is the exact position of the filter's acceptance window. The pre-divider runs freely and its phase is not visible, so the bench cannot aim at one tick. Instead it uses durations that hold for any phase. A pulse shorter than two sample intervals must always be dropped. A level held for three intervals plus the synchroniser delay must always be taken. For the top codes, a hold time between the 32-clock and 64-clock thresholds separates the 64-clock interval from its neighbour, and this shows that the codes 6 and 7 really give the slowest rate.

// File: rtl/enc_front.sv
module enc_front #(
  parameter int NCH = 3,
  parameter int PW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_en,
  input  logic           flt_bypass,
  input  logic [2:0]     div_sel,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_inv,
  input  logic [NCH-1:0] enc_in,
  output logic [NCH-1:0] lvl_out,
  output logic           idx_rise
);
  localparam int ZI = NCH - 1;

  logic [NCH-1:0] s1, s2, cond, flt;
  logic [NCH-1:0][1:0] hist;
  logic [PW-1:0] pcnt, pmask;
  logic tick, z_prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= enc_in;
      s2 <= s1;
    end

  assign cond = ch_en & (s2 ^ ch_inv);

  always_comb
    case (div_sel)
      3'd0:    pmask = PW'(0);
      3'd1:    pmask = PW'(1);
      3'd2:    pmask = PW'(3);
      3'd3:    pmask = PW'(15);
      3'd4:    pmask = PW'(31);
      default: pmask = PW'(63);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt + 1'b1;

  assign tick = ((pcnt & pmask) == pmask);

  for (genvar g = 0; g < NCH; g++) begin : g_flt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hist[g] <= '0;
        flt[g]  <= 1'b0;
      end else if (!ctl_en) begin
        hist[g] <= '0;
        flt[g]  <= 1'b0;
      end else if (tick) begin
        hist[g] <= {hist[g][0], cond[g]};
        if (hist[g][1] == cond[g] && hist[g][0] == cond[g])
          flt[g] <= cond[g];
      end
  end

  assign lvl_out = ctl_en ? (flt_bypass ? cond : flt) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) z_prev <= 1'b0;
    else        z_prev <= lvl_out[ZI];

  assign idx_rise = lvl_out[ZI] & ~z_prev;

  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rise |=> !idx_rise);

  a_r8_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rise |-> lvl_out[ZI]);

  a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && !tick) |=> $stable(flt));

  a_r3_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && flt_bypass) |-> ((lvl_out & ~ch_en) == '0));

  a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> (flt == '0 && hist == '0));
endmodule

// File: tb/enc_front_test.sv
`timescale 1ns/1ps
module enc_front_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_en, flt_bypass;
  logic [2:0] div_sel, ch_en, ch_inv, enc_in, lvl_out;
  logic idx_rise;
  int total = 0, errs = 0;

  enc_front uut (.clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .flt_bypass(flt_bypass),
    .div_sel(div_sel), .ch_en(ch_en), .ch_inv(ch_inv), .enc_in(enc_in),
    .lvl_out(lvl_out), .idx_rise(idx_rise));

  always #2.5 clk = ~clk;

  // {en, inv, bypass, raw, expected}
  localparam logic [12:0] VEC [12] = '{
    {3'b111, 3'b000, 1'b1, 3'b101, 3'b101},
    {3'b111, 3'b111, 1'b1, 3'b101, 3'b010},
    {3'b111, 3'b010, 1'b0, 3'b000, 3'b010},
    {3'b011, 3'b000, 1'b0, 3'b111, 3'b011},
    {3'b101, 3'b000, 1'b1, 3'b111, 3'b101},
    {3'b000, 3'b111, 1'b1, 3'b010, 3'b000},
    {3'b110, 3'b001, 1'b0, 3'b110, 3'b110},
    {3'b111, 3'b100, 1'b0, 3'b011, 3'b111},
    {3'b010, 3'b010, 1'b1, 3'b010, 3'b000},
    {3'b111, 3'b011, 1'b0, 3'b100, 3'b111},
    {3'b100, 3'b100, 1'b1, 3'b000, 3'b100},
    {3'b001, 3'b001, 1'b0, 3'b001, 3'b000}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic count_rise(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (idx_rise) cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - errs, total);
    $finish;
  end

  initial begin
    int pc;
    ctl_en = 1'b1; flt_bypass = 1'b1; div_sel = 3'd0;
    ch_en = 3'b111; ch_inv = 3'b000; enc_in = 3'b111;
    wait_n(4);
    chk("R10 levels in reset", lvl_out, 3'b000);
    chk("R10 strobe in reset", {2'b00, idx_rise}, 3'b000);
    enc_in = 3'b000;
    wait_n(1);
    rst_n = 1'b1;
    wait_n(3);
    chk("R10 levels after reset", lvl_out, 3'b000);

    // R1: two edges through the synchroniser
    enc_in = 3'b001;
    wait_n(1);
    chk("R1 one edge", lvl_out, 3'b000);
    wait_n(1);
    chk("R1 two edges", lvl_out, 3'b001);
    enc_in = 3'b000;
    wait_n(4);

    // R2 R3 R4 table
    for (int i = 0; i < 12; i++) begin
      ch_en = VEC[i][12:10];
      ch_inv = VEC[i][9:7];
      flt_bypass = VEC[i][6];
      enc_in = VEC[i][5:3];
      wait_n(10);
      chk($sformatf("R2/R3/R4 vector %0d", i), lvl_out, VEC[i][2:0]);
    end

    // R5 R6: glitch rejection and acceptance per code
    ch_en = 3'b111; ch_inv = 3'b000; flt_bypass = 1'b0; enc_in = 3'b000;
    for (int c = 0; c < 5; c++) begin
      int nd;
      nd = (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 4 : (c == 3) ? 16 : 32;
      div_sel = 3'(c);
      wait_n(200);
      enc_in = 3'b001;
      wait_n(2 * nd - 1);
      enc_in = 3'b000;
      wait_n(3 * nd + 6);
      chk($sformatf("R5 glitch rejected code %0d", c), lvl_out, 3'b000);
      enc_in = 3'b001;
      wait_n(3 * nd + 6);
      chk($sformatf("R6 accepted code %0d", c), lvl_out, 3'b001);
      enc_in = 3'b000;
      wait_n(3 * nd + 6);
    end

    // R6 R7: codes 5..7 all sample every 64 clocks
    for (int c = 5; c < 8; c++) begin
      div_sel = 3'(c);
      enc_in = 3'b000;
      wait_n(220);
      enc_in = 3'b010;
      wait_n(110);
      chk($sformatf("R7 not yet taken code %0d", c), lvl_out, 3'b000);
      wait_n(100);
      chk($sformatf("R7 taken code %0d", c), lvl_out, 3'b010);
    end
    enc_in = 3'b000;
    div_sel = 3'd0;
    wait_n(220);

    // R8 index strobe
    enc_in = 3'b100;
    count_rise(20, pc);
    chk("R8 one strobe on rise", 3'(pc), 3'd1);
    enc_in = 3'b000;
    count_rise(20, pc);
    chk("R8 no strobe on fall", 3'(pc), 3'd0);

    // R9 global enable
    flt_bypass = 1'b1;
    ctl_en = 1'b0;
    enc_in = 3'b111;
    count_rise(10, pc);
    chk("R9 levels off", lvl_out, 3'b000);
    chk("R9 no strobe off", 3'(pc), 3'd0);
    ctl_en = 1'b1;
    wait_n(1);
    chk("R9 bypass back on", lvl_out, 3'b111);
    flt_bypass = 1'b0;
    wait_n(10);
    ctl_en = 1'b0;
    wait_n(5);
    ctl_en = 1'b1;
    wait_n(1);
    chk("R9 filter cleared", lvl_out, 3'b000);
    wait_n(10);
    chk("R9 filter refilled", lvl_out, 3'b111);

    $display("%0d/%0d checks passed", total - errs, total);
    $finish;
  end
endmodule